// File: doc/BRIEF.md
# Handshaked Byte Transfer Engine

This block is the device end of a three-wire, active-low handshake carried over a byte-wide shift register. The host writes a control port. Bit 5 of that port is the in-progress line and bit 4 is the acknowledge line. A low level means asserted on both. The engine answers on a request line (`req_n`), which takes the place of bit 3 of the same port. A direction input selects what happens while a transfer is active. When the host is sending, each handshake step copies the shift byte into a 16-slot outbound store. When the device is sending, each step loads the next byte of a reply, which may hold up to 128 bytes, into the shift byte.

Every byte step, every sync step and every transfer end raises a one-cycle shift-flag request. Loading a new reply raises it too. When a host transfer closes with data held, a one-cycle packet pulse carries the byte count. A packet decoder downstream reads the bytes out of the outbound store by index, then composes a reply and loads it through the reply write port.

Edges are found by comparing each control-port write with the in-progress/acknowledge pair captured at the previous control-port write. Writes that repeat the stored pair do no byte step.

Top module: `hsx_engine`

## Requirements
- R1: After reset, `req_n` is 1, `shift_set` and `pkt_valid` are 0, `shift_byte` is 0, no outbound bytes are held, and the stored pair reads idle with acknowledge high.
- R2: With in-progress low (bit 5 = 0) and `host_to_dev` = 1, a control write whose pair differs from the stored pair copies the present shift byte into outbound slot `count` and increments `count`. One cycle after the write, `shift_set` pulses.
- R3: Once 16 outbound bytes are held, further pair changes in host-send mode store nothing and raise no `shift_set`.
- R4: A control write that repeats the stored pair does no byte step. While idle with no unread reply, it also raises no `shift_set` and leaves `req_n` unchanged.
- R5: With in-progress low and `host_to_dev` = 0, each pair change loads the next unread reply byte into `shift_byte` and pulses `shift_set`. Once every reply byte has been loaded, a pair change does nothing.
- R6: The step that loads the last reply byte drives `req_n` to 1.
- R7: When the stored pair and the written pair are both idle (bit 5 = 1) and bit 4 differs, `req_n` takes the written bit 4 and `shift_set` pulses.
- R8: A write that takes in-progress from asserted to idle always pulses `shift_set`. If any outbound bytes were held, `pkt_valid` pulses in the same cycle with `pkt_len` equal to the count, and the count returns to zero.
- R9: An idle control write that is not a sync step drives `req_n` to 0 when unread reply bytes remain.
- R10: `reply_go` sets the reply length to `reply_len` (clamped to 128), resets the read index to zero and pulses `shift_set`. The next device-send step loads reply slot 0.
- R11: `sr_wr` writes `sr_wdata` into `shift_byte` unless a reply byte is loaded in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_wdata | input | 8 | Control-port write value; bit 5 in-progress, bit 4 acknowledge, both active low |
| host_to_dev | input | 1 | 1: host sends bytes, 0: device sends bytes |
| sr_wr | input | 1 | Host write strobe for the shift byte |
| sr_wdata | input | 8 | Shift byte written by the host |
| reply_wr | input | 1 | Write strobe for one reply slot |
| reply_widx | input | 7 | Reply slot index |
| reply_wdata | input | 8 | Reply slot data |
| reply_go | input | 1 | Commit a new reply of `reply_len` bytes |
| reply_len | input | 8 | Reply length in bytes |
| out_rd_idx | input | 4 | Outbound slot to read |
| out_rd_data | output | 8 | Outbound slot contents |
| req_n | output | 1 | Active-low transfer request to the host |
| shift_byte | output | 8 | Current shift byte |
| shift_set | output | 1 | One-cycle request to set the shift flag |
| pkt_valid | output | 1 | One-cycle pulse: a host packet has arrived |
| pkt_len | output | 5 | Byte count of the arrived packet |

## Verification
The hardest state to reach from the ports is the outbound store sitting exactly full while the host keeps toggling acknowledge. The stimulus gets there with a sweep of host packet lengths from 1 to 18. Each length needs a full sequence: set the shift byte, assert in-progress, then toggle acknowledge. The bench computes the expected slot contents and the clamped count arithmetically for every length. A second sweep over reply lengths walks the read index to its end. It checks the release of the request line on the last byte and the silent step after it. A partial reply that is then replaced shows that the read index restarts.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
    // Active-low control-port line positions
    localparam int ACK_POS = 4;
    localparam int TIP_POS = 5;

    // Kind of step a control-port write triggers
    typedef enum logic [2:0] {
        XF_NONE,
        XF_STORE,
        XF_LOAD,
        XF_SYNC,
        XF_END,
        XF_IDLE
    } xfer_e;
endpackage

// File: rtl/hsx_bytebuf.sv
module hsx_bytebuf #(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/hsx_ctrl.sv
module hsx_ctrl
    import hsx_pkg::*;
#(
    parameter  int OUT_DEPTH = 16,
    parameter  int IN_DEPTH  = 128,
    parameter  int DW        = 8,
    localparam int OCW       = $clog2(OUT_DEPTH + 1),
    localparam int OIW       = $clog2(OUT_DEPTH),
    localparam int ICW       = $clog2(IN_DEPTH + 1),
    localparam int IIW       = $clog2(IN_DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctl_wr,
    input  logic [7:0]     ctl_wdata,
    input  logic           host_to_dev,
    input  logic           sr_wr,
    input  logic [DW-1:0]  sr_wdata,
    input  logic           reply_go,
    input  logic [ICW-1:0] reply_len,
    input  logic [DW-1:0]  in_rd_data,
    output logic [IIW-1:0] in_rd_idx,
    output logic           st_en,
    output logic [OIW-1:0] st_idx,
    output logic [DW-1:0]  st_data,
    output logic           req_n,
    output logic [DW-1:0]  shift_byte,
    output logic           shift_set,
    output logic           pkt_valid,
    output logic [OCW-1:0] pkt_len
);
    typedef struct packed {
        logic [1:0]     pair;      // {in-progress, acknowledge} at last write
        logic           req_n;
        logic [DW-1:0]  shift;
        logic [OCW-1:0] out_cnt;
        logic [ICW-1:0] in_idx;
        logic [ICW-1:0] in_len;
        logic           shift_set;
        logic           pkt_valid;
        logic [OCW-1:0] pkt_len;
    } st_t;

    st_t   q, d;
    xfer_e kind;

    logic [1:0]     cur_pair;
    logic           pair_chg, ack_chg, tip_act, was_act, unread, has_room;
    logic [ICW-1:0] idx_inc;
    logic           unused_ctl;

    assign unused_ctl = ^{ctl_wdata[7:6], ctl_wdata[3:0]};

    assign cur_pair = {ctl_wdata[TIP_POS], ctl_wdata[ACK_POS]};
    assign pair_chg = (cur_pair != q.pair);
    assign ack_chg  = (cur_pair[0] != q.pair[0]);
    assign tip_act  = ~cur_pair[1];
    assign was_act  = ~q.pair[1];
    assign unread   = (q.in_idx < q.in_len);
    assign has_room = (q.out_cnt < OCW'(OUT_DEPTH));
    assign idx_inc  = q.in_idx + ICW'(1);

    // Classify the step a control-port write performs
    always_comb begin
        kind = XF_NONE;
        if (ctl_wr) begin
            if (tip_act) begin
                if (host_to_dev) begin
                    kind = (pair_chg && has_room) ? XF_STORE : XF_NONE;
                end else begin
                    kind = (pair_chg && unread) ? XF_LOAD : XF_NONE;
                end
            end else if (!was_act && ack_chg) begin
                kind = XF_SYNC;
            end else if (was_act) begin
                kind = XF_END;
            end else begin
                kind = XF_IDLE;
            end
        end
    end

    // Next-state computation
    always_comb begin
        d           = q;
        d.shift_set = 1'b0;
        d.pkt_valid = 1'b0;
        st_en       = 1'b0;

        if (sr_wr) begin
            d.shift = sr_wdata;
        end

        unique case (kind)
            XF_STORE: begin
                st_en       = 1'b1;
                d.out_cnt   = q.out_cnt + OCW'(1);
                d.shift_set = 1'b1;
            end
            XF_LOAD: begin
                d.shift     = in_rd_data;
                d.in_idx    = idx_inc;
                d.shift_set = 1'b1;
                if (idx_inc >= q.in_len) begin
                    d.req_n = 1'b1;
                end
            end
            XF_SYNC: begin
                d.req_n     = cur_pair[0];
                d.shift_set = 1'b1;
            end
            XF_END: begin
                d.shift_set = 1'b1;
                if (q.out_cnt != '0) begin
                    d.pkt_valid = 1'b1;
                    d.pkt_len   = q.out_cnt;
                end
                d.out_cnt = '0;
                if (unread) begin
                    d.req_n = 1'b0;
                end
            end
            XF_IDLE: begin
                if (unread) begin
                    d.req_n = 1'b0;
                end
            end
            default: ;
        endcase

        if (ctl_wr) begin
            d.pair = cur_pair;
        end

        if (reply_go) begin
            d.in_len    = (reply_len > ICW'(IN_DEPTH)) ? ICW'(IN_DEPTH) : reply_len;
            d.in_idx    = '0;
            d.shift_set = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q           <= '0;
            q.pair      <= 2'b11;
            q.req_n     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign st_idx     = q.out_cnt[OIW-1:0];
    assign st_data    = q.shift;
    assign in_rd_idx  = q.in_idx[IIW-1:0];
    assign req_n      = q.req_n;
    assign shift_byte = q.shift;
    assign shift_set  = q.shift_set;
    assign pkt_valid  = q.pkt_valid;
    assign pkt_len    = q.pkt_len;

    // R3: the outbound count never passes the store depth
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.out_cnt <= OCW'(OUT_DEPTH));

    // R3: a host-send step on a full store raises no flag
    p_full_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && host_to_dev && !ctl_wdata[TIP_POS]
         && q.out_cnt == OCW'(OUT_DEPTH) && !reply_go) |=> !shift_set);

    // R5: the reply read index never passes the reply length
    p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.in_idx <= q.in_len);

    // R8: a packet pulse carries a nonzero count and a flag request
    p_pkt_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (shift_set && pkt_len != '0));

    // R7: an idle-to-idle acknowledge change is mirrored on the request line
    p_sync_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[TIP_POS] && q.pair[1]
         && (ctl_wdata[ACK_POS] != q.pair[0]))
        |=> (req_n == $past(ctl_wdata[ACK_POS])));

    // R10: every flag request follows a control write or a reply commit
    p_flag_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        shift_set |-> $past(ctl_wr || reply_go));
endmodule

// File: rtl/hsx_engine.sv
module hsx_engine #(
    parameter  int OUT_DEPTH = 16,
    parameter  int IN_DEPTH  = 128,
    parameter  int DW        = 8,
    localparam int OCW       = $clog2(OUT_DEPTH + 1),
    localparam int OIW       = $clog2(OUT_DEPTH),
    localparam int ICW       = $clog2(IN_DEPTH + 1),
    localparam int IIW       = $clog2(IN_DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctl_wr,
    input  logic [7:0]     ctl_wdata,
    input  logic           host_to_dev,
    input  logic           sr_wr,
    input  logic [DW-1:0]  sr_wdata,
    input  logic           reply_wr,
    input  logic [IIW-1:0] reply_widx,
    input  logic [DW-1:0]  reply_wdata,
    input  logic           reply_go,
    input  logic [ICW-1:0] reply_len,
    input  logic [OIW-1:0] out_rd_idx,
    output logic [DW-1:0]  out_rd_data,
    output logic           req_n,
    output logic [DW-1:0]  shift_byte,
    output logic           shift_set,
    output logic           pkt_valid,
    output logic [OCW-1:0] pkt_len
);
    logic           st_en;
    logic [OIW-1:0] st_idx;
    logic [DW-1:0]  st_data;
    logic [IIW-1:0] in_rd_idx;
    logic [DW-1:0]  in_rd_data;

    hsx_ctrl #(
        .OUT_DEPTH (OUT_DEPTH),
        .IN_DEPTH  (IN_DEPTH),
        .DW        (DW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .host_to_dev (host_to_dev),
        .sr_wr       (sr_wr),
        .sr_wdata    (sr_wdata),
        .reply_go    (reply_go),
        .reply_len   (reply_len),
        .in_rd_data  (in_rd_data),
        .in_rd_idx   (in_rd_idx),
        .st_en       (st_en),
        .st_idx      (st_idx),
        .st_data     (st_data),
        .req_n       (req_n),
        .shift_byte  (shift_byte),
        .shift_set   (shift_set),
        .pkt_valid   (pkt_valid),
        .pkt_len     (pkt_len)
    );

    // Bytes arriving from the host
    hsx_bytebuf #(
        .DEPTH (OUT_DEPTH),
        .DW    (DW)
    ) u_outbuf (
        .clk     (clk),
        .wr_en   (st_en),
        .wr_idx  (st_idx),
        .wr_data (st_data),
        .rd_idx  (out_rd_idx),
        .rd_data (out_rd_data)
    );

    // Reply bytes waiting for the host
    hsx_bytebuf #(
        .DEPTH (IN_DEPTH),
        .DW    (DW)
    ) u_inbuf (
        .clk     (clk),
        .wr_en   (reply_wr),
        .wr_idx  (reply_widx),
        .wr_data (reply_wdata),
        .rd_idx  (in_rd_idx),
        .rd_data (in_rd_data)
    );
endmodule

// File: tb/hsx_engine_test.sv
module hsx_engine_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h30;
    logic       host_to_dev = 1'b1;
    logic       sr_wr = 1'b0;
    logic [7:0] sr_wdata = 8'h00;
    logic       reply_wr = 1'b0;
    logic [6:0] reply_widx = '0;
    logic [7:0] reply_wdata = '0;
    logic       reply_go = 1'b0;
    logic [7:0] reply_len = '0;
    logic [3:0] out_rd_idx = '0;
    logic [7:0] out_rd_data;
    logic       req_n;
    logic [7:0] shift_byte;
    logic       shift_set;
    logic       pkt_valid;
    logic [4:0] pkt_len;

    int  n_chk = 0;
    int  n_fail = 0;
    logic cur_ack = 1'b1;

    always #2 clk = ~clk;

    hsx_engine uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .host_to_dev(host_to_dev), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .reply_wr(reply_wr), .reply_widx(reply_widx), .reply_wdata(reply_wdata),
        .reply_go(reply_go), .reply_len(reply_len), .out_rd_idx(out_rd_idx),
        .out_rd_data(out_rd_data), .req_n(req_n), .shift_byte(shift_byte),
        .shift_set(shift_set), .pkt_valid(pkt_valid), .pkt_len(pkt_len)
    );

    function automatic logic [7:0] hb(input int n, input int i);
        return 8'((n * 16 + i * 5 + 3) & 255);
    endfunction

    function automatic logic [7:0] db(input int m, input int i);
        return 8'((m * 29 + i * 11 + 7) & 255);
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put_ctl(input logic ack, input logic tip);
        @(negedge clk);
        ctl_wr    = 1'b1;
        ctl_wdata = {2'b00, tip, ack, 4'b0000};
        cur_ack   = ack;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic put_sr(input logic [7:0] v);
        @(negedge clk);
        sr_wr    = 1'b1;
        sr_wdata = v;
        @(negedge clk);
        sr_wr = 1'b0;
    endtask

    task automatic load_reply(input int m);
        for (int i = 0; i < m; i++) begin
            @(negedge clk);
            reply_wr    = 1'b1;
            reply_widx  = 7'(i);
            reply_wdata = db(m, i);
        end
        @(negedge clk);
        reply_wr  = 1'b0;
        reply_go  = 1'b1;
        reply_len = 8'(m);
        @(negedge clk);
        reply_go = 1'b0;
        check(int'(shift_set), 1, "R10 flag on reply load");
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(int'(req_n), 1, "R1 req_n");
        check(int'(shift_set), 0, "R1 shift_set");
        check(int'(pkt_valid), 0, "R1 pkt_valid");
        check(int'(shift_byte), 0, "R1 shift_byte");

        // R7: sync handshake while idle
        put_ctl(1'b0, 1'b1);
        check(int'(req_n), 0, "R7 req follows ack low");
        check(int'(shift_set), 1, "R7 flag");
        put_ctl(1'b1, 1'b1);
        check(int'(req_n), 1, "R7 req follows ack high");
        check(int'(shift_set), 1, "R7 flag");
        // R4: repeated idle pair does nothing
        put_ctl(1'b1, 1'b1);
        check(int'(shift_set), 0, "R4 idle repeat flag");
        check(int'(req_n), 1, "R4 idle repeat req");

        // R2/R3/R8: host-send sweep over packet lengths
        host_to_dev = 1'b1;
        for (int n = 1; n <= 18; n++) begin
            int held;
            held = (n < 16) ? n : 16;
            for (int i = 0; i < n; i++) begin
                put_sr(hb(n, i));
                check(int'(shift_byte), int'(hb(n, i)), "R11 shift write");
                if (i == 0) put_ctl(cur_ack, 1'b0);
                else        put_ctl(~cur_ack, 1'b0);
                check(int'(shift_set), (i < 16) ? 1 : 0, "R2/R3 store flag");
                if (n == 3 && i == 0) begin
                    put_ctl(cur_ack, 1'b0);
                    check(int'(shift_set), 0, "R4 active repeat flag");
                end
            end
            put_ctl(cur_ack, 1'b1);
            check(int'(shift_set), 1, "R8 end flag");
            check(int'(pkt_valid), 1, "R8 pkt_valid");
            check(int'(pkt_len), held, "R8 pkt_len");
            for (int i = 0; i < held; i++) begin
                out_rd_idx = 4'(i);
                #1;
                check(int'(out_rd_data), int'(hb(n, i)), "R2 stored byte");
            end
        end

        // R8: a transfer with nothing held raises the flag but no packet
        host_to_dev = 1'b0;
        put_ctl(cur_ack, 1'b0);
        check(int'(shift_set), 0, "R5 no reply, no load");
        put_ctl(cur_ack, 1'b1);
        check(int'(shift_set), 1, "R8 empty end flag");
        check(int'(pkt_valid), 0, "R8 empty end no packet");

        // R5/R6/R9/R10: device-send sweep over reply lengths
        for (int m = 1; m <= 6; m++) begin
            load_reply(m);
            check(int'(req_n), 1, "R9 req idle before request");
            put_ctl(cur_ack, 1'b1);
            check(int'(req_n), 0, "R9 req asserted for unread reply");
            for (int i = 0; i < m; i++) begin
                if (i == 0) put_ctl(cur_ack, 1'b0);
                else        put_ctl(~cur_ack, 1'b0);
                check(int'(shift_byte), int'(db(m, i)), "R5 loaded byte");
                check(int'(shift_set), 1, "R5 load flag");
                check(int'(req_n), (i == m - 1) ? 1 : 0, "R6 req release");
            end
            put_ctl(~cur_ack, 1'b0);
            check(int'(shift_set), 0, "R5 exhausted no flag");
            check(int'(shift_byte), int'(db(m, m - 1)), "R5 exhausted byte held");
            put_ctl(cur_ack, 1'b1);
            check(int'(shift_set), 1, "R8 end flag device send");
            check(int'(pkt_valid), 0, "R8 no packet device send");
            check(int'(req_n), 1, "R9 no unread keeps req high");
        end

        // R9/R10: partial reply, then a fresh reply restarts at slot 0
        load_reply(4);
        put_ctl(cur_ack, 1'b1);
        put_ctl(cur_ack, 1'b0);
        put_ctl(~cur_ack, 1'b0);
        check(int'(shift_byte), int'(db(4, 1)), "R5 partial second byte");
        put_ctl(cur_ack, 1'b1);
        check(int'(req_n), 0, "R9 unread after end");
        load_reply(3);
        put_ctl(cur_ack, 1'b0);
        check(int'(shift_byte), int'(db(3, 0)), "R10 index restart");
        put_ctl(cur_ack, 1'b1);

        finish_up();
    end
endmodule